// File: doc/BRIEF.md
# Delay-Line Tap Stepper

This block walks two programmable delay lines, one on the read path and one on the write path, from their power-on tap positions to requested tap values. The delay elements accept only a serial control interface: a reset line per element, a clock-enable per element, a shared increment/decrement line and a shared control strobe. The stepper produces that sequence of control pulses. The block's clock is independent of the strobe.

A single-cycle `start` pulse samples both requested taps and limits them to the 6-bit tap range. The stepper then strobes both elements once with their resets held. This puts the read line at tap 16 and the write line at tap 32. It then issues one three-phase pulse per tap until the read line matches its request, and after that does the same for the write line. Each phase lasts a fixed number of block clocks. When both tracked positions equal their requests, `done` rises and stays high. A new `start` abandons any sequence in progress and begins again from the reset pulse.

Top module: `tap_stepper`

## Requirements
- R1: After `rst_n` is released, every control output and `done` are low until `start` is seen.
- R2: `start` captures `rd_target` and `wr_target`. A value above 63 is treated as 63. Changes on the target inputs after the `start` cycle have no effect on the sequence that follows.
- R3: Every sequence opens with three phases in which both reset outputs are high and neither clock-enable is high. `dly_strobe` is high only during the middle phase.
- R4: Once the reset pulse has occurred, the stepper takes the read position to be 16 and the write position to be 32.
- R5: `dly_up` is 1 while the tracked position of the active line is below its request and 0 while it is above. Each step moves the tracked position by exactly one, and the number of steps equals the distance to the request.
- R6: Each step has three phases of `PHASE_CYC` clocks each: enable with direction, then enable with direction and `dly_strobe`, then enable with direction. The enable is therefore high for 3·`PHASE_CYC` clocks and the strobe for `PHASE_CYC` clocks.
- R7: All read steps use `dly_ce_rd` and all complete before any write step starts on `dly_ce_wr`. The two enables are never high together.
- R8: With N total steps, `done` rises (3·`PHASE_CYC`+1)·(N+1) clocks after the clock edge that samples `start`. While `done` is high, all control outputs are low and both tracked positions equal their requests.
- R9: A `start` during a sequence in progress clears `done` and restarts from the reset pulse, using the newly captured targets.
- R10: When the requests equal 16 and 32, the only strobe is the reset pulse and no clock-enable is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a new sequence |
| rd_target | input | TGT_W | Requested read-line tap |
| wr_target | input | TGT_W | Requested write-line tap |
| dly_rst_rd | output | 1 | Reset control of the read delay element |
| dly_rst_wr | output | 1 | Reset control of the write delay element |
| dly_ce_rd | output | 1 | Clock-enable of the read delay element |
| dly_ce_wr | output | 1 | Clock-enable of the write delay element |
| dly_up | output | 1 | Direction: 1 increments, 0 decrements |
| dly_strobe | output | 1 | Control strobe shared by both elements |
| done | output | 1 | Both lines are at their requested taps |

## Verification
The assertions check the following on every cycle: the strobe only appears inside a reset frame or a single enable, the two enables never overlap, a write enable only appears once the read position matches, the direction is held across a step, the strobe never exceeds one phase, and `done` implies idle outputs with both positions matched. The bench's scenarios show what no single-cycle property can. These are the final tap of a behavioural delay-element model, the exact step count and the cycle on which `done` rises. They also cover the clamping of large requests, immunity to target changes mid-run, and a restart that lands partway through the read steps.

// File: rtl/tapstep_pkg.sv
package tapstep_pkg;

  // Sequencer states: three reset phases, a one-cycle selector,
  // three phases per read step, three per write step, and the rest state.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_A,
    ST_RST_B,
    ST_RST_C,
    ST_SEL,
    ST_RD_A,
    ST_RD_B,
    ST_RD_C,
    ST_WR_A,
    ST_WR_B,
    ST_WR_C,
    ST_DONE
  } step_state_e;

  // Limit a raw request to the largest legal tap.
  function automatic logic [15:0] clamp_target(input logic [15:0] raw,
                                               input logic [15:0] max_tap);
    return (raw > max_tap) ? max_tap : raw;
  endfunction

  // One tap toward the request, or stay put when already there.
  function automatic logic [15:0] step_toward(input logic [15:0] cur,
                                              input logic [15:0] goal);
    if (cur < goal) return cur + 16'd1;
    if (cur > goal) return cur - 16'd1;
    return cur;
  endfunction

  // True when the state belongs to a timed phase.
  function automatic logic is_timed(input step_state_e s);
    return (s != ST_IDLE) && (s != ST_SEL) && (s != ST_DONE);
  endfunction

endpackage

// File: rtl/tapstep_phase_timer.sv
module tapstep_phase_timer #(
  parameter int unsigned PHASE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic timed,
  output logic phase_end
);
  localparam int unsigned CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || !timed) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // The phase ends on the cycle the count reaches its last value.
  assign phase_end = timed && (cnt == LAST);

endmodule

// File: rtl/tapstep_tracker.sv
module tapstep_tracker #(
  parameter int unsigned TAP_W     = 6,
  parameter int unsigned TGT_W     = 8,
  parameter int unsigned RESET_TAP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TGT_W-1:0] raw_target,
  input  logic             step,
  output logic [TAP_W-1:0] cur,
  output logic [TAP_W-1:0] goal,
  output logic             match,
  output logic             go_up
);
  import tapstep_pkg::*;

  localparam logic [15:0]      MAX_TAP   = 16'((1 << TAP_W) - 1);
  localparam logic [TAP_W-1:0] START_TAP = TAP_W'(RESET_TAP);

  logic [TAP_W-1:0] goal_in;
  logic [TAP_W-1:0] cur_next;

  assign goal_in  = TAP_W'(clamp_target(16'(raw_target), MAX_TAP));
  assign cur_next = TAP_W'(step_toward(16'(cur), 16'(goal)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= START_TAP;
      goal <= START_TAP;
    end else if (load) begin
      cur  <= START_TAP;
      goal <= goal_in;
    end else if (step) begin
      cur  <= cur_next;
    end
  end

  assign match = (cur == goal);
  assign go_up = (cur < goal);

endmodule

// File: rtl/tapstep_fsm.sv
module tapstep_fsm (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     phase_end,
  input  logic                     rd_match,
  input  logic                     wr_match,
  output tapstep_pkg::step_state_e state,
  output logic                     timed,
  output logic                     rd_step,
  output logic                     wr_step
);
  import tapstep_pkg::*;

  step_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RST_A: if (phase_end) nxt = ST_RST_B;
      ST_RST_B: if (phase_end) nxt = ST_RST_C;
      ST_RST_C: if (phase_end) nxt = ST_SEL;
      ST_SEL: begin
        if (!rd_match)      nxt = ST_RD_A;
        else if (!wr_match) nxt = ST_WR_A;
        else                nxt = ST_DONE;
      end
      ST_RD_A:  if (phase_end) nxt = ST_RD_B;
      ST_RD_B:  if (phase_end) nxt = ST_RD_C;
      ST_RD_C:  if (phase_end) nxt = ST_SEL;
      ST_WR_A:  if (phase_end) nxt = ST_WR_B;
      ST_WR_B:  if (phase_end) nxt = ST_WR_C;
      ST_WR_C:  if (phase_end) nxt = ST_SEL;
      default:  nxt = state;
    endcase
    if (start) nxt = ST_RST_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign timed   = is_timed(state);
  // A step is committed as its trailing phase closes.
  assign rd_step = (state == ST_RD_C) && phase_end && !start;
  assign wr_step = (state == ST_WR_C) && phase_end && !start;

endmodule

// File: rtl/tap_stepper.sv
module tap_stepper #(
  parameter int unsigned TAP_W     = 6,
  parameter int unsigned TGT_W     = 8,
  parameter int unsigned PHASE_CYC = 2,
  parameter int unsigned RD_HOME   = 16,
  parameter int unsigned WR_HOME   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TGT_W-1:0] rd_target,
  input  logic [TGT_W-1:0] wr_target,
  output logic             dly_rst_rd,
  output logic             dly_rst_wr,
  output logic             dly_ce_rd,
  output logic             dly_ce_wr,
  output logic             dly_up,
  output logic             dly_strobe,
  output logic             done
);
  import tapstep_pkg::*;

  // Internal events brought out by name for the checker.
  step_state_e      state;
  logic             timed;
  logic             phase_end;
  logic             rd_step, wr_step;
  logic             rd_match, wr_match;
  logic             rd_up, wr_up;
  logic [TAP_W-1:0] rd_cur, rd_goal, wr_cur, wr_goal;
  logic             in_rst, in_rd, in_wr;

  tapstep_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .phase_end (phase_end),
    .rd_match  (rd_match),
    .wr_match  (wr_match),
    .state     (state),
    .timed     (timed),
    .rd_step   (rd_step),
    .wr_step   (wr_step)
  );

  tapstep_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start || phase_end),
    .timed     (timed),
    .phase_end (phase_end)
  );

  tapstep_tracker #(.TAP_W(TAP_W), .TGT_W(TGT_W), .RESET_TAP(RD_HOME)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .raw_target (rd_target),
    .step       (rd_step),
    .cur        (rd_cur),
    .goal       (rd_goal),
    .match      (rd_match),
    .go_up      (rd_up)
  );

  tapstep_tracker #(.TAP_W(TAP_W), .TGT_W(TGT_W), .RESET_TAP(WR_HOME)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .raw_target (wr_target),
    .step       (wr_step),
    .cur        (wr_cur),
    .goal       (wr_goal),
    .match      (wr_match),
    .go_up      (wr_up)
  );

  // Output decode straight from the state register.
  assign in_rst = (state == ST_RST_A) || (state == ST_RST_B) || (state == ST_RST_C);
  assign in_rd  = (state == ST_RD_A)  || (state == ST_RD_B)  || (state == ST_RD_C);
  assign in_wr  = (state == ST_WR_A)  || (state == ST_WR_B)  || (state == ST_WR_C);

  assign dly_rst_rd = in_rst;
  assign dly_rst_wr = in_rst;
  assign dly_ce_rd  = in_rd;
  assign dly_ce_wr  = in_wr;
  assign dly_up     = (in_rd && rd_up) || (in_wr && wr_up);
  assign dly_strobe = (state == ST_RST_B) || (state == ST_RD_B) || (state == ST_WR_B);
  assign done       = (state == ST_DONE);

endmodule

// File: rtl/tapstep_checker.sv
module tapstep_checker #(
  parameter int unsigned PHASE_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic dly_rst_rd,
  input logic dly_rst_wr,
  input logic dly_ce_rd,
  input logic dly_ce_wr,
  input logic dly_up,
  input logic dly_strobe,
  input logic done,
  input logic rd_match,
  input logic wr_match,
  input logic rd_step,
  input logic wr_step
);
  // Consecutive cycles for which the strobe has already been high.
  int unsigned stb_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stb_run <= 0;
    else if (dly_strobe) stb_run <= stb_run + 1;
    else                 stb_run <= 0;
  end

  p_reset_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dly_rst_rd |-> (dly_rst_wr && !dly_ce_rd && !dly_ce_wr));

  p_ce_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dly_ce_rd && dly_ce_wr));

  p_wr_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dly_ce_wr |-> rd_match);

  p_no_wr_step_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_step |-> (rd_match && !rd_step));

  p_strobe_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dly_strobe |-> (dly_rst_rd || dly_ce_rd || dly_ce_wr));

  p_strobe_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dly_strobe |-> (stb_run < PHASE_CYC));

  p_dir_held_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_ce_rd && $past(dly_ce_rd)) |-> $stable(dly_up));

  p_dir_held_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_ce_wr && $past(dly_ce_wr)) |-> $stable(dly_up));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(dly_strobe || dly_ce_rd || dly_ce_wr || dly_rst_rd));

  p_done_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_match && wr_match));

  p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dly_rst_rd && !done));

endmodule

bind tap_stepper tapstep_checker #(.PHASE_CYC(PHASE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .dly_rst_rd (dly_rst_rd),
  .dly_rst_wr (dly_rst_wr),
  .dly_ce_rd  (dly_ce_rd),
  .dly_ce_wr  (dly_ce_wr),
  .dly_up     (dly_up),
  .dly_strobe (dly_strobe),
  .done       (done),
  .rd_match   (rd_match),
  .wr_match   (wr_match),
  .rd_step    (rd_step),
  .wr_step    (wr_step)
);

// File: tb/sim_tap_stepper.sv
module sim_tap_stepper;
  localparam int CLK_PERIOD = 10;
  localparam int PH         = 2;
  localparam int TW         = 8;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [TW-1:0] rd_target = '0;
  logic [TW-1:0] wr_target = '0;
  logic dly_rst_rd, dly_rst_wr, dly_ce_rd, dly_ce_wr, dly_up, dly_strobe, done;

  tap_stepper #(.TAP_W(6), .TGT_W(TW), .PHASE_CYC(PH)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_target(rd_target), .wr_target(wr_target),
    .dly_rst_rd(dly_rst_rd), .dly_rst_wr(dly_rst_wr),
    .dly_ce_rd(dly_ce_rd), .dly_ce_wr(dly_ce_wr),
    .dly_up(dly_up), .dly_strobe(dly_strobe), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Behavioural delay-element model, sampled away from the active edge.
  int  m_rd = 0, m_wr = 0;
  int  n_rst = 0, n_rd = 0, n_wr = 0;
  int  exp_rd = 16;
  int  stb_len = 0, ce_len = 0;
  bit  prev_stb = 0;
  bit  skip_len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dly_strobe && !prev_stb) begin
        if (dly_rst_rd && dly_rst_wr) begin
          m_rd = 16; m_wr = 32; n_rst++;
        end else if (dly_ce_rd && !dly_ce_wr) begin
          if (n_wr != 0) chk(0, "R7 read step after write step", n_wr, 0);
          m_rd = dly_up ? m_rd + 1 : m_rd - 1;
          n_rd++;
        end else if (dly_ce_wr && !dly_ce_rd) begin
          chk(m_rd == exp_rd, "R7 read done before write step", m_rd, exp_rd);
          m_wr = dly_up ? m_wr + 1 : m_wr - 1;
          n_wr++;
        end else begin
          chk(0, "R6 strobe without single enable", 0, 1);
        end
      end
      if (dly_strobe) stb_len++;
      else if (stb_len != 0) begin
        if (!skip_len) chk(stb_len == PH, "R6 strobe width", stb_len, PH);
        stb_len = 0;
      end
      if (dly_ce_rd || dly_ce_wr) ce_len++;
      else if (ce_len != 0) begin
        if (!skip_len) chk(ce_len == 3*PH, "R6 enable width", ce_len, 3*PH);
        ce_len = 0;
      end
      prev_stb = dly_strobe;
    end
  end

  function automatic int clampv(input int v);
    return (v > 63) ? 63 : v;
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // Called at a negedge: pulse start for one sampling edge.
  task automatic kick(input int rd, input int wr);
    rd_target = TW'(rd);
    wr_target = TW'(wr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_rst = 0; n_rd = 0; n_wr = 0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic verify(input int rd, input int wr, input int k, input string tag);
    int erd, ewr, nsteps;
    erd = clampv(rd);
    ewr = clampv(wr);
    nsteps = absd(erd, 16) + absd(ewr, 32);
    chk(done == 1'b1, {tag, " R8 done"}, done, 1);
    chk(k == (3*PH+1)*(nsteps+1), {tag, " R8 latency"}, k, (3*PH+1)*(nsteps+1));
    chk(n_rst == 1, {tag, " R3 one reset strobe"}, n_rst, 1);
    chk(m_rd == erd, {tag, " R5 read tap"}, m_rd, erd);
    chk(m_wr == ewr, {tag, " R5 write tap"}, m_wr, ewr);
    chk(n_rd == absd(erd, 16), {tag, " R4 read steps from 16"}, n_rd, absd(erd, 16));
    chk(n_wr == absd(ewr, 32), {tag, " R4 write steps from 32"}, n_wr, absd(ewr, 32));
    @(negedge clk);
    chk(done && !dly_strobe && !dly_ce_rd && !dly_ce_wr && !dly_rst_rd,
        {tag, " R8 done holds idle"}, done, 1);
  endtask

  task automatic t_reset_state();
    chk({dly_rst_rd, dly_rst_wr, dly_ce_rd, dly_ce_wr, dly_up, dly_strobe} == 6'b0,
        "R1 controls idle", {dly_rst_rd, dly_rst_wr, dly_ce_rd, dly_ce_wr, dly_up, dly_strobe}, 0);
    chk(done == 1'b0, "R1 done low", done, 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && !dly_strobe, "R1 stays idle without start", done, 0);
  endtask

  task automatic t_case(input int rd, input int wr, input string tag);
    int k;
    exp_rd = clampv(rd);
    kick(rd, wr);
    wait_done(k);
    verify(rd, wr, k, tag);
  endtask

  task automatic t_inputs_ignored();
    int k;
    exp_rd = 20;
    kick(20, 40);
    rd_target = 8'd3;   // R2: later changes must not matter
    wr_target = 8'd60;
    wait_done(k);
    verify(20, 40, k, "R2 latched");
  endtask

  task automatic t_no_steps();
    int k;
    exp_rd = 16;
    kick(16, 32);
    wait_done(k);
    verify(16, 32, k, "R10 home");
    chk(n_rd == 0 && n_wr == 0, "R10 no enable strobes", n_rd + n_wr, 0);
  endtask

  task automatic t_restart();
    int k;
    exp_rd = 30;
    kick(30, 40);
    repeat (7) @(negedge clk);   // now in the first read step
    chk(dly_ce_rd == 1'b1, "R9 mid-run before restart", dly_ce_rd, 1);
    skip_len = 1;
    exp_rd = 5;
    kick(5, 50);
    chk(dly_rst_rd && !done, "R9 reset pulse restarts", dly_rst_rd, 1);
    wait_done(k);
    verify(5, 50, k, "R9 restart");
    skip_len = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_case(20, 40, "R5 up");
    t_case(10, 25, "R5 down");
    t_case(40, 12, "R7 mixed");
    t_inputs_ignored();
    t_case(200, 0, "R2 clamp");
    t_case(17, 32, "R6 single");
    t_no_steps();
    t_restart();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule